// File: doc/BRIEF.md
# Wide-burst local memory loader

This sequencer prepares a processing core's 512-word local register memory before the core begins running. On a start command that carries a hub code address and a hub parameter address, it walks through shared hub memory in wide reads of eight words each. Each word is copied into local memory, beginning at local address 0x000. After the code region is full, the four special locations directly above it are zeroed. The block then raises a one-cycle jump strobe, which tells the core to begin execution at local address 0x000.

Two pointer outputs are seeded at the moment a start is accepted. One holds the parameter address and the other holds the code address, so the loaded program can find both. The hub side keeps at most one wide read outstanding at a time and tolerates any response latency. The local side issues at most one word write per cycle.

A code address that is not aligned to a wide boundary is refused with a one-cycle error pulse, and nothing else happens. A start that arrives while a load is in progress is ignored.

Top module: `wl_loader`

## Requirements
- R1: An aligned start (`code_addr_i[2:0] == 0`) accepted while idle raises `busy_o` from the next cycle and issues exactly 62 single-cycle hub reads, at addresses code, code+8, code+16 and so on, ascending modulo 2^20. Only one read is outstanding at a time.
- R2: Local writes of a load go to addresses 0x000, 0x001, … in strict ascending order, one address per write. Within a wide, word j (bits `32*j+31:32*j` of `hub_data_i`) goes to the lower address before word j+1.
- R3: Local address a (0x000 ≤ a ≤ 0x1EF) receives the hub word at (code + a) modulo 2^20, so exactly 496 words are loaded.
- R4: After the 496th word, addresses 0x1F0, 0x1F1, 0x1F2 and 0x1F3 are written with zero. No address above 0x1F3 is ever written, and each load makes exactly 500 writes.
- R5: `ptr_par_o` and `ptr_code_o` take the parameter and code addresses in the cycle after an aligned start is accepted. They hold those values until the next accepted start.
- R6: `jump_o` is high for exactly one cycle, in the cycle after the write to 0x1F3. During that cycle no local write occurs. `busy_o` is low in the following cycle.
- R7: A start whose code address has any of its low three bits set produces a one-cycle `err_o` pulse in the next cycle. It issues no hub read and no local write, and it leaves the pointers and `busy_o` unchanged.
- R8: A start asserted while `busy_o` is high, including in the cycle `jump_o` is high, is ignored. It does not alter the pointers, the write sequence or the read addresses, and it does not start a new load.
- R9: `hub_valid_i` has an effect only while a read is outstanding. A response at any other time changes no written data.
- R10: After reset, `busy_o`, `jump_o`, `err_o`, `lm_we_o` and `hub_rd_o` are low, and both pointers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command strobe |
| code_addr_i | input | 20 | Hub word address of the code image |
| par_addr_i | input | 20 | Hub word address of the parameter block |
| hub_rd_o | output | 1 | Wide read request, one cycle |
| hub_addr_o | output | 20 | Hub word address of the wide read |
| hub_valid_i | input | 1 | Wide read data valid |
| hub_data_i | input | 256 | Eight-word read data, word 0 in the low bits |
| lm_we_o | output | 1 | Local memory write enable |
| lm_addr_o | output | 9 | Local memory write address |
| lm_data_o | output | 32 | Local memory write data |
| ptr_par_o | output | 20 | Pointer seeded with the parameter address |
| ptr_code_o | output | 20 | Pointer seeded with the code address |
| busy_o | output | 1 | Load in progress |
| jump_o | output | 1 | Start execution at local address 0x000 |
| err_o | output | 1 | Misaligned start refused |

## Verification
The collision of interest is a new start command landing in the same cycle as the jump strobe, or anywhere else in a running load. To provoke it, the bench asserts start exactly when it sees `jump_o`, and at random points while busy, with fresh addresses. It then judges that the pointers still hold the old addresses, that `busy_o` falls and stays low, and that no extra read or write appears. A second collision comes from stray `hub_valid_i` pulses, injected while the loader is writing or idle. These are judged by comparing every written word against the hub contents computed by the bench.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_WAIT  = 3'd2,
    ST_WRITE = 3'd3,
    ST_CLEAR = 3'd4,
    ST_JUMP  = 3'd5
  } wl_state_e;
endpackage

// File: rtl/wl_ctrl.sv
module wl_ctrl
  import wl_pkg::*;
#(
  parameter int BURST       = 8,
  parameter int N_WIDES     = 62,
  parameter int CLEAR_WORDS = 4,
  localparam int BEAT_W     = $clog2(BURST),
  localparam int WIDE_W     = $clog2(N_WIDES),
  localparam int CLR_W      = $clog2(CLEAR_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              aligned_i,
  input  logic              hub_valid_i,
  output logic              accept_o,
  output logic              rd_issue_o,
  output logic              capture_o,
  output logic              wr_en_o,
  output logic              clr_en_o,
  output logic              jump_o,
  output logic              err_o,
  output logic              busy_o,
  output logic [WIDE_W-1:0] wide_idx_o,
  output logic [BEAT_W-1:0] beat_o
);

  wl_state_e          state_q, state_d;
  logic [BEAT_W-1:0]  beat_q, beat_d;
  logic [WIDE_W-1:0]  wide_q, wide_d;
  logic [CLR_W-1:0]   clr_q, clr_d;
  logic               err_q, err_d;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    wide_d  = wide_q;
    clr_d   = clr_q;
    err_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (aligned_i) begin
            state_d = ST_REQ;
            wide_d  = '0;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_REQ: state_d = ST_WAIT;
      ST_WAIT: begin
        if (hub_valid_i) begin
          state_d = ST_WRITE;
          beat_d  = '0;
        end
      end
      ST_WRITE: begin
        if (beat_q == BEAT_W'(BURST - 1)) begin
          if (wide_q == WIDE_W'(N_WIDES - 1)) begin
            state_d = ST_CLEAR;
            clr_d   = '0;
          end else begin
            state_d = ST_REQ;
            wide_d  = wide_q + 1'b1;
          end
        end else begin
          beat_d = beat_q + 1'b1;
        end
      end
      ST_CLEAR: begin
        if (clr_q == CLR_W'(CLEAR_WORDS - 1)) begin
          state_d = ST_JUMP;
        end else begin
          clr_d = clr_q + 1'b1;
        end
      end
      ST_JUMP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      wide_q  <= '0;
      clr_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      wide_q  <= wide_d;
      clr_q   <= clr_d;
      err_q   <= err_d;
    end
  end

  assign accept_o   = (state_q == ST_IDLE) && start_i && aligned_i;
  assign rd_issue_o = (state_q == ST_REQ);
  assign capture_o  = (state_q == ST_WAIT) && hub_valid_i;
  assign wr_en_o    = (state_q == ST_WRITE);
  assign clr_en_o   = (state_q == ST_CLEAR);
  assign jump_o     = (state_q == ST_JUMP);
  assign busy_o     = (state_q != ST_IDLE);
  assign err_o      = err_q;
  assign wide_idx_o = wide_q;
  assign beat_o     = beat_q;

  // jump strobe lasts a single cycle (R6)
  assert_jump_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    jump_o |=> !jump_o);

  // a refused start leaves the loader idle with no hub traffic (R7)
  assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy_o && !rd_issue_o));

  // a start seen while busy never restarts the sequence (R8)
  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !jump_o && start_i) |=> busy_o);

  // hub read and local write never share a cycle (R1)
  assert_rd_not_wr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue_o |-> !(wr_en_o || clr_en_o));

endmodule

// File: rtl/wl_fetch.sv
module wl_fetch #(
  parameter int DATA_W = 32,
  parameter int HUB_AW = 20,
  parameter int BURST  = 8,
  parameter int WIDE_W = 6,
  localparam int BEAT_W = $clog2(BURST),
  localparam int WIDE_BITS = BURST * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept_i,
  input  logic [HUB_AW-1:0]    code_addr_i,
  input  logic                 rd_issue_i,
  input  logic                 capture_i,
  input  logic [WIDE_BITS-1:0] hub_data_i,
  input  logic [WIDE_W-1:0]    wide_idx_i,
  input  logic [BEAT_W-1:0]    beat_i,
  output logic                 hub_rd_o,
  output logic [HUB_AW-1:0]    hub_addr_o,
  output logic [DATA_W-1:0]    word_o
);

  logic [HUB_AW-1:0] base_q;
  logic [DATA_W-1:0] buf_q [BURST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (accept_i) begin
      base_q <= code_addr_i;
    end
  end

  for (genvar g = 0; g < BURST; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_q[g] <= '0;
      end else if (capture_i) begin
        buf_q[g] <= hub_data_i[g*DATA_W +: DATA_W];
      end
    end
  end

  assign hub_rd_o   = rd_issue_i;
  assign hub_addr_o = base_q + HUB_AW'({wide_idx_i, {BEAT_W{1'b0}}});
  assign word_o     = buf_q[beat_i];

  // every wide read lands on a wide boundary (R1)
  assert_hub_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hub_rd_o |-> (hub_addr_o[BEAT_W-1:0] == '0));

endmodule

// File: rtl/wl_writer.sv
module wl_writer #(
  parameter int DATA_W      = 32,
  parameter int LM_AW       = 9,
  parameter int LOAD_WORDS  = 496,
  parameter int CLEAR_WORDS = 4,
  localparam int LAST_ADDR  = LOAD_WORDS + CLEAR_WORDS - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              wr_en_i,
  input  logic              clr_en_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              lm_we_o,
  output logic [LM_AW-1:0]  lm_addr_o,
  output logic [DATA_W-1:0] lm_data_o
);

  logic [LM_AW-1:0] idx_q, idx_d;
  logic             idx_en;

  assign idx_en = accept_i || wr_en_i || clr_en_i;

  always_comb begin
    if (accept_i) begin
      idx_d = '0;
    end else begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign lm_we_o   = wr_en_i || clr_en_i;
  assign lm_addr_o = idx_q;
  assign lm_data_o = wr_en_i ? word_i : '0;

  // no write above the last special location (R4)
  assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lm_we_o |-> (lm_addr_o <= LM_AW'(LAST_ADDR)));

  // special locations only ever receive zero (R4)
  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lm_we_o && (lm_addr_o >= LM_AW'(LOAD_WORDS))) |-> (lm_data_o == '0));

  // back-to-back writes step the index by one (R2)
  assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lm_we_o && $past(lm_we_o)) |-> (lm_addr_o == $past(lm_addr_o) + 1'b1));

endmodule

// File: rtl/wl_loader.sv
module wl_loader #(
  parameter int DATA_W      = 32,
  parameter int HUB_AW      = 20,
  parameter int BURST       = 8,
  parameter int LOAD_WORDS  = 496,
  parameter int CLEAR_WORDS = 4,
  parameter int LM_AW       = 9,
  localparam int N_WIDES    = LOAD_WORDS / BURST,
  localparam int BEAT_W     = $clog2(BURST),
  localparam int WIDE_W     = $clog2(N_WIDES),
  localparam int WIDE_BITS  = BURST * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [HUB_AW-1:0]    code_addr_i,
  input  logic [HUB_AW-1:0]    par_addr_i,
  output logic                 hub_rd_o,
  output logic [HUB_AW-1:0]    hub_addr_o,
  input  logic                 hub_valid_i,
  input  logic [WIDE_BITS-1:0] hub_data_i,
  output logic                 lm_we_o,
  output logic [LM_AW-1:0]     lm_addr_o,
  output logic [DATA_W-1:0]    lm_data_o,
  output logic [HUB_AW-1:0]    ptr_par_o,
  output logic [HUB_AW-1:0]    ptr_code_o,
  output logic                 busy_o,
  output logic                 jump_o,
  output logic                 err_o
);

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              aligned;
  logic              accept, rd_issue, capture, wr_en, clr_en;
  logic [WIDE_W-1:0] wide_idx;
  logic [BEAT_W-1:0] beat;
  logic [DATA_W-1:0] word;

  assign aligned = (code_addr_i[BEAT_W-1:0] == '0);

  wl_ctrl #(
    .BURST       (BURST),
    .N_WIDES     (N_WIDES),
    .CLEAR_WORDS (CLEAR_WORDS)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_i     (start_i),
    .aligned_i   (aligned),
    .hub_valid_i (hub_valid_i),
    .accept_o    (accept),
    .rd_issue_o  (rd_issue),
    .capture_o   (capture),
    .wr_en_o     (wr_en),
    .clr_en_o    (clr_en),
    .jump_o      (jump_o),
    .err_o       (err_o),
    .busy_o      (busy_o),
    .wide_idx_o  (wide_idx),
    .beat_o      (beat)
  );

  wl_fetch #(
    .DATA_W (DATA_W),
    .HUB_AW (HUB_AW),
    .BURST  (BURST),
    .WIDE_W (WIDE_W)
  ) u_fetch (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .accept_i    (accept),
    .code_addr_i (code_addr_i),
    .rd_issue_i  (rd_issue),
    .capture_i   (capture),
    .hub_data_i  (hub_data_i),
    .wide_idx_i  (wide_idx),
    .beat_i      (beat),
    .hub_rd_o    (hub_rd_o),
    .hub_addr_o  (hub_addr_o),
    .word_o      (word)
  );

  wl_writer #(
    .DATA_W      (DATA_W),
    .LM_AW       (LM_AW),
    .LOAD_WORDS  (LOAD_WORDS),
    .CLEAR_WORDS (CLEAR_WORDS)
  ) u_writer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept_i  (accept),
    .wr_en_i   (wr_en),
    .clr_en_i  (clr_en),
    .word_i    (word),
    .lm_we_o   (lm_we_o),
    .lm_addr_o (lm_addr_o),
    .lm_data_o (lm_data_o)
  );

  logic [HUB_AW-1:0] ptr_par_q, ptr_code_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ptr_par_q  <= '0;
      ptr_code_q <= '0;
    end else if (accept) begin
      ptr_par_q  <= par_addr_i;
      ptr_code_q <= code_addr_i;
    end
  end

  assign ptr_par_o  = ptr_par_q;
  assign ptr_code_o = ptr_code_q;

  // pointers hold steady for the whole load (R5)
  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy_o && $past(busy_o)) |-> ($stable(ptr_par_o) && $stable(ptr_code_o)));

  // local writes only happen inside a load (R4)
  assert_we_busy_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lm_we_o |-> busy_o);

endmodule

// File: tb/tb_wl_loader.sv
`timescale 1ns/1ps
module tb_wl_loader;

  localparam int LOADW = 496;
  localparam int TOTALW = 500;
  localparam int NWIDE = 62;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [19:0]  code_addr_i, par_addr_i;
  logic         hub_rd_o;
  logic [19:0]  hub_addr_o;
  logic         hub_valid_i;
  logic [255:0] hub_data_i;
  logic         lm_we_o;
  logic [8:0]   lm_addr_o;
  logic [31:0]  lm_data_o;
  logic [19:0]  ptr_par_o, ptr_code_o;
  logic         busy_o, jump_o, err_o;

  int errors = 0;
  int checks = 0;
  bit spur_en = 1'b0;

  always #2 clk = ~clk;

  wl_loader dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .code_addr_i(code_addr_i),
    .par_addr_i(par_addr_i), .hub_rd_o(hub_rd_o), .hub_addr_o(hub_addr_o),
    .hub_valid_i(hub_valid_i), .hub_data_i(hub_data_i), .lm_we_o(lm_we_o),
    .lm_addr_o(lm_addr_o), .lm_data_o(lm_data_o), .ptr_par_o(ptr_par_o),
    .ptr_code_o(ptr_code_o), .busy_o(busy_o), .jump_o(jump_o), .err_o(err_o)
  );

  function automatic logic [31:0] hubword(logic [19:0] a);
    return ({12'h0, a} * 32'h9E3779B1) ^ 32'h5A5A_0000 ^ {12'h0, a};
  endfunction

  function automatic logic [255:0] hubwide(logic [19:0] a);
    logic [255:0] w;
    for (int j = 0; j < 8; j++) w[j*32 +: 32] = hubword(a + 20'(j));
    return w;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // hub memory model: one outstanding read, random latency, stray responses
  bit          pend = 1'b0;
  int          lat = 0;
  logic [19:0] paddr;
  always @(negedge clk) begin
    if (!rst_n) begin
      pend = 1'b0;
      hub_valid_i = 1'b0;
      hub_data_i = '0;
    end else begin
      hub_valid_i = 1'b0;
      if (hub_rd_o) begin
        pend = 1'b1;
        lat = 1 + int'($urandom % 4);
        paddr = hub_addr_o;
      end else if (pend) begin
        if (lat == 1) begin
          hub_valid_i = 1'b1;
          hub_data_i = hubwide(paddr);
          pend = 1'b0;
        end else begin
          lat--;
        end
      end else if (spur_en && ($urandom % 5 == 0)) begin
        hub_valid_i = 1'b1;
        hub_data_i = {8{$urandom}};
      end
    end
  end

  task automatic quiet(int n, logic [19:0] pp, logic [19:0] pc, string req);
    for (int i = 0; i < n; i++) begin
      chk(!lm_we_o && !hub_rd_o && !busy_o, req, {lm_we_o, hub_rd_o, busy_o}, 0);
      chk(ptr_par_o == pp && ptr_code_o == pc, req, ptr_par_o, pp);
      @(negedge clk);
    end
  endtask

  task automatic run_load(logic [19:0] code, logic [19:0] par, bit hit_jump);
    int  wr = 0;
    int  rd = 0;
    int  cyc = 0;
    bit  done = 0;
    @(negedge clk);
    start_i = 1'b1; code_addr_i = code; par_addr_i = par;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R1 busy after accept", busy_o, 1);
    chk(ptr_par_o == par, "R5 par pointer", ptr_par_o, par);
    chk(ptr_code_o == code, "R5 code pointer", ptr_code_o, code);
    while (!done && cyc < 20000) begin
      start_i = 1'b0;
      if (lm_we_o) begin
        chk(wr < TOTALW, "R4 write count", wr, TOTALW);
        chk(lm_addr_o == 9'(wr), "R2 write order", lm_addr_o, wr);
        if (wr < LOADW)
          chk(lm_data_o == hubword(code + 20'(wr)), "R3 loaded word", lm_data_o,
              hubword(code + 20'(wr)));
        else
          chk(lm_data_o == 0, "R4 special clear", lm_data_o, 0);
        wr++;
      end
      if (hub_rd_o) begin
        chk(hub_addr_o == code + 20'(rd * 8), "R1 wide address", hub_addr_o,
            code + 20'(rd * 8));
        rd++;
      end
      if (jump_o) begin
        done = 1;
        chk(!lm_we_o, "R6 no write at jump", lm_we_o, 0);
        chk(wr == TOTALW, "R4 total writes", wr, TOTALW);
        chk(rd == NWIDE, "R1 read count", rd, NWIDE);
        chk(ptr_par_o == par && ptr_code_o == code, "R8 pointers kept",
            ptr_code_o, code);
        if (hit_jump) begin
          start_i = 1'b1;
          code_addr_i = 20'($urandom) & 20'hFFFF8;
          par_addr_i = 20'($urandom);
        end
      end else if (busy_o && ($urandom % 40 == 0)) begin
        start_i = 1'b1;
        code_addr_i = 20'($urandom);
        par_addr_i = 20'($urandom);
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    chk(done, "R6 jump reached", done, 1);
    chk(!jump_o, "R6 jump one cycle", jump_o, 0);
    chk(!busy_o, "R8 idle after jump", busy_o, 1'b0);
    quiet(3, par, code, "R8 no restart");
  endtask

  task automatic bad_start(logic [19:0] code, logic [19:0] par);
    logic [19:0] pp = ptr_par_o;
    logic [19:0] pc = ptr_code_o;
    @(negedge clk);
    start_i = 1'b1; code_addr_i = code; par_addr_i = par;
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o == 1'b1, "R7 error pulse", err_o, 1);
    chk(!busy_o, "R7 stays idle", busy_o, 0);
    @(negedge clk);
    chk(err_o == 1'b0, "R7 error one cycle", err_o, 0);
    quiet(4, pp, pc, "R7 no traffic");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; code_addr_i = '0; par_addr_i = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy_o && !jump_o && !err_o, "R10 reset flags", {busy_o, jump_o, err_o}, 0);
    chk(!lm_we_o && !hub_rd_o, "R10 reset strobes", {lm_we_o, hub_rd_o}, 0);
    chk(ptr_par_o == 0 && ptr_code_o == 0, "R10 reset pointers", ptr_code_o, 0);
    spur_en = 1'b1;
    // directed corners: zero base, wrapping base, start on the jump cycle
    run_load(20'h00000, 20'h12345, 1'b0);
    run_load(20'hFFF08, 20'h00010, 1'b1);
    bad_start(20'h00403, 20'h0ABCD);
    bad_start(20'hFFFFF, 20'h00001);
    // constrained random loads mixed with refused starts (R9 via stray responses)
    for (int n = 0; n < 10; n++) begin
      if ($urandom % 4 == 0)
        bad_start((20'($urandom) & 20'hFFFF8) | 20'(1 + $urandom % 7), 20'($urandom));
      run_load(20'($urandom) & 20'hFFFF8, 20'($urandom), 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

endmodule